// File: doc/BRIEF.md
# Gate Enable and Fault Reset Sequencer

This block sequences the power-up and power-down of a gate driver from a single enable input, and it produces a clear pulse for the fault latches and status registers. When the enable input rises from the fully-off state, the auxiliary blocks (charge pump, regulator, current amplifiers) are switched on at once. The gate driver is enabled after a settle count.

When enable drops, the gate driver is turned off on the next clock. The block then counts how long enable stays low. If enable returns high before the low-time window expires, this is a quick reset: the auxiliary blocks and the serial interface stay up, the gate driver comes straight back, and the fault latches are cleared. If enable stays low for the whole window, this is a full shutdown: the auxiliary blocks are dropped and the serial interface is marked not ready.

A reset-gate command from the serial register interface clears faults without any shutdown. A gate-supply overvoltage input sets a sticky flag, and that flag keeps the gate driver off. Only a full shutdown clears this flag, and only if the overvoltage condition has gone away by then.

Top module: `gate_seq_top`

## Requirements
- R1: After reset, and until the first low-to-high transition of `en_in` seen after reset, all five outputs are 0. An `en_in` that is already high when reset is released does not count as a transition.
- R2: On the clock edge where a rising `en_in` is sampled in the fully-off state, `aux_en` and `spi_ready` go to 1. `drv_en` goes to 1 exactly SETTLE_CYC edges later, provided `en_in` stays high.
- R3: On any clock edge where `en_in` is sampled low, `drv_en` goes to 0.
- R4: When `en_in` is sampled low on LOW_WIN_CYC consecutive edges, `aux_en` and `spi_ready` go to 0 on the edge that samples the last of those low cycles.
- R5: When `en_in` returns high after at most LOW_WIN_CYC-1 low samples, `aux_en` and `spi_ready` never drop. In that case `drv_en` goes back to 1 on the same edge that samples `en_in` high again, with no settle count (unless R8 applies).
- R6: `clr_pulse` is 1 for one cycle after each of these events: a rise from fully off, a quick reset, and a `rst_gate_cmd` accepted while the serial interface stays ready.
- R7: `rst_gate_cmd` is ignored while `spi_ready` is 0. In that case `clr_pulse` stays 0 and no other output changes.
- R8: When `ovp_in` is sampled high, `ovp_flag` goes to 1 and holds `drv_en` at 0. Neither a quick reset nor `rst_gate_cmd` clears the flag.
- R9: A full shutdown (R4) clears `ovp_flag` only if `ovp_in` is low on that edge. If `ovp_in` is still high, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| en_in | input | 1 | Enable level from the host |
| rst_gate_cmd | input | 1 | Reset-gate command strobe from the register interface |
| ovp_in | input | 1 | Gate-supply overvoltage condition present |
| drv_en | output | 1 | Gate driver enable (0 means outputs high impedance) |
| aux_en | output | 1 | Auxiliary blocks enable |
| spi_ready | output | 1 | Serial interface usable |
| clr_pulse | output | 1 | One-cycle clear for fault latches and status registers |
| ovp_flag | output | 1 | Latched gate-supply overvoltage |

## Verification
Suppose the low-time counter is off by one. Then a low pulse of exactly LOW_WIN_CYC or LOW_WIN_CYC-1 cycles is classified the wrong way, and this shows at the ports as early as the edge that would end the window: `aux_en` drops when it should not, or stays up when it should drop. A wrong settle count moves the rising edge of `drv_en` away from its expected cycle after power-up. A wrong sequencer state shows within one edge as a missing or extra `clr_pulse`. A flag-clear path that is wrongly shared shows as `ovp_flag` falling after a quick toggle or after a command.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,  // fully shut down, auxiliary blocks off
    ST_SETTLE = 2'd1,  // auxiliary up, waiting before gate enable
    ST_RUN    = 2'd2,  // gate driver active
    ST_LOWQ   = 2'd3   // enable low, timing quick versus full shutdown
  } seq_state_t;
endpackage

// File: rtl/gate_seq_edge.sv
module gate_seq_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_in,
  output logic rise
);
  logic lvl_q;

  // Reset value 1: a level already high at reset release is not an edge
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b1;
    else     lvl_q <= lvl_in;
  end

  assign rise = lvl_in & ~lvl_q;
endmodule

// File: rtl/gate_seq_cnt.sv
module gate_seq_cnt #(
  parameter int TERM = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic at_term
);
  localparam int CW = $clog2(TERM + 2);
  localparam logic [CW-1:0] TERM_V = CW'(TERM);

  logic [CW-1:0] cnt;

  // Counts cycles spent in the owning state; cleared whenever outside it
  always_ff @(posedge clk) begin
    if (rst || !run)    cnt <= '0;
    else if (!at_term)  cnt <= cnt + 1'b1;
  end

  assign at_term = run && (cnt == TERM_V);
endmodule

// File: rtl/gate_seq_ovp.sv
module gate_seq_ovp (
  input  logic clk,
  input  logic rst,
  input  logic ovp_in,
  input  logic full_evt,
  output logic flag_nxt,
  output logic flag
);
  // Sticky: only a full shutdown with the condition gone releases it
  assign flag_nxt = ovp_in | (flag & ~full_evt);

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= flag_nxt;
  end
endmodule

// File: rtl/gate_seq_ctrl.sv
module gate_seq_ctrl
  import gate_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en_in,
  input  logic       en_rise,
  input  logic       cmd,
  input  logic       settle_done,
  input  logic       low_done,
  input  logic       ovp_nxt,
  output seq_state_t state,
  output logic       full_evt,
  output logic       drv_q,
  output logic       aux_q,
  output logic       rdy_q,
  output logic       clr_q
);
  seq_state_t nxt;
  logic       ev_clr;
  logic       cmd_ok;

  always_comb begin
    nxt      = state;
    ev_clr   = 1'b0;
    full_evt = 1'b0;
    unique case (state)
      ST_OFF: begin
        if (en_rise) begin
          nxt    = ST_SETTLE;
          ev_clr = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (!en_in)           nxt = ST_LOWQ;
        else if (settle_done) nxt = ST_RUN;
      end
      ST_RUN: begin
        if (!en_in) nxt = ST_LOWQ;
      end
      ST_LOWQ: begin
        if (en_in) begin
          nxt    = ST_RUN;
          ev_clr = 1'b1;
        end else if (low_done) begin
          nxt      = ST_OFF;
          full_evt = 1'b1;
        end
      end
      default: nxt = ST_OFF;
    endcase
  end

  // Command only honoured while the interface is up now and stays up
  assign cmd_ok = cmd && (state != ST_OFF) && (nxt != ST_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OFF;
      drv_q <= 1'b0;
      aux_q <= 1'b0;
      rdy_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      state <= nxt;
      drv_q <= (nxt == ST_RUN) && !ovp_nxt;
      aux_q <= (nxt != ST_OFF);
      rdy_q <= (nxt != ST_OFF);
      clr_q <= ev_clr | cmd_ok;
    end
  end
endmodule

// File: rtl/gate_seq_top.sv
module gate_seq_top
  import gate_seq_pkg::*;
#(
  parameter int LOW_WIN_CYC = 500,  // clock frequency times the low-time window
  parameter int SETTLE_CYC  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en_in,
  input  logic rst_gate_cmd,
  input  logic ovp_in,
  output logic drv_en,
  output logic aux_en,
  output logic spi_ready,
  output logic clr_pulse,
  output logic ovp_flag
);
  localparam int LOW_TERM    = LOW_WIN_CYC - 2;
  localparam int SETTLE_TERM = SETTLE_CYC - 1;

  seq_state_t state;
  logic en_rise, settle_done, low_done, full_evt, ovp_nxt;

  initial begin
    if (LOW_WIN_CYC < 2) $error("LOW_WIN_CYC must be at least 2");
    if (SETTLE_CYC < 1)  $error("SETTLE_CYC must be at least 1");
  end

  gate_seq_edge i_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_in (en_in),
    .rise   (en_rise)
  );

  gate_seq_cnt #(.TERM(SETTLE_TERM)) i_settle_cnt (
    .clk     (clk),
    .rst     (rst),
    .run     (state == ST_SETTLE),
    .at_term (settle_done)
  );

  gate_seq_cnt #(.TERM(LOW_TERM)) i_low_cnt (
    .clk     (clk),
    .rst     (rst),
    .run     (state == ST_LOWQ),
    .at_term (low_done)
  );

  gate_seq_ovp i_ovp (
    .clk      (clk),
    .rst      (rst),
    .ovp_in   (ovp_in),
    .full_evt (full_evt),
    .flag_nxt (ovp_nxt),
    .flag     (ovp_flag)
  );

  gate_seq_ctrl i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .en_in       (en_in),
    .en_rise     (en_rise),
    .cmd         (rst_gate_cmd),
    .settle_done (settle_done),
    .low_done    (low_done),
    .ovp_nxt     (ovp_nxt),
    .state       (state),
    .full_evt    (full_evt),
    .drv_q       (drv_en),
    .aux_q       (aux_en),
    .rdy_q       (spi_ready),
    .clr_q       (clr_pulse)
  );
endmodule

// File: rtl/gate_seq_chk.sv
module gate_seq_chk (
  input logic clk,
  input logic rst,
  input logic en_in,
  input logic ovp_in,
  input logic drv_en,
  input logic aux_en,
  input logic spi_ready,
  input logic clr_pulse,
  input logic ovp_flag
);
  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !spi_ready |-> (!drv_en && !aux_en));

  assert_low_kills_drv_R3: assert property (@(posedge clk) disable iff (rst)
    !en_in |=> !drv_en);

  assert_clr_when_ready_R6: assert property (@(posedge clk) disable iff (rst)
    clr_pulse |-> spi_ready);

  assert_no_clr_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    (!spi_ready && !en_in) |=> !clr_pulse);

  assert_ovp_blocks_drv_R8: assert property (@(posedge clk) disable iff (rst)
    ovp_flag |-> !drv_en);

  assert_ovp_sticks_R9: assert property (@(posedge clk) disable iff (rst)
    ovp_in |=> ovp_flag);
endmodule

bind gate_seq_top gate_seq_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .en_in     (en_in),
  .ovp_in    (ovp_in),
  .drv_en    (drv_en),
  .aux_en    (aux_en),
  .spi_ready (spi_ready),
  .clr_pulse (clr_pulse),
  .ovp_flag  (ovp_flag)
);

// File: tb/test_gate_seq_top.sv
module test_gate_seq_top;
  localparam int NLOW = 6;
  localparam int NSET = 3;
  localparam int NVEC = 31;

  // bits: [7]en [6]cmd [5]ovp | expected [4]drv [3]aux [2]spi [1]clr [0]ovpf
  localparam logic [7:0] VEC [NVEC] = '{
    8'b000_00000, // 1  R1 off
    8'b010_00000, // 2  R7 cmd ignored while off
    8'b100_01110, // 3  R2 rise: aux, ready, clear
    8'b100_01100, // 4  R2 settle
    8'b100_01100, // 5  R2 settle
    8'b100_11100, // 6  R2 drv after SETTLE_CYC
    8'b110_11110, // 7  R6 command clear
    8'b100_11100, // 8  R6 single pulse
    8'b000_01100, // 9  R3 drv off at once
    8'b000_01100, // 10 R3
    8'b100_11110, // 11 R5 quick reset
    8'b101_01101, // 12 R8 ovp latches, drv off
    8'b110_01111, // 13 R8 command does not clear ovp
    8'b000_01101, // 14 R8
    8'b100_01111, // 15 R8 quick reset does not clear ovp
    8'b000_01101, // 16 R4 low count 1
    8'b000_01101, // 17 R4
    8'b000_01101, // 18 R4
    8'b000_01101, // 19 R4
    8'b000_01101, // 20 R4
    8'b000_00000, // 21 R4/R9 full shutdown clears ovp
    8'b100_01110, // 22 R2 power up again
    8'b100_01100, // 23 R2
    8'b100_01100, // 24 R2
    8'b100_11100, // 25 R2
    8'b000_01100, // 26 R5 low 1
    8'b000_01100, // 27 R5
    8'b000_01100, // 28 R5
    8'b000_01100, // 29 R5
    8'b000_01100, // 30 R5 low 5 = window-1
    8'b100_11110  // 31 R5 still quick
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_in = 1'b0, rst_gate_cmd = 1'b0, ovp_in = 1'b0;
  logic drv_en, aux_en, spi_ready, clr_pulse, ovp_flag;
  int   total = 0, bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  gate_seq_top #(.LOW_WIN_CYC(NLOW), .SETTLE_CYC(NSET)) i_gate_seq_top (
    .clk (clk), .rst (rst), .en_in (en_in), .rst_gate_cmd (rst_gate_cmd),
    .ovp_in (ovp_in), .drv_en (drv_en), .aux_en (aux_en),
    .spi_ready (spi_ready), .clr_pulse (clr_pulse), .ovp_flag (ovp_flag)
  );

  function automatic string req_of(int i);
    if (i < 1)  return "R1";
    if (i < 2)  return "R7";
    if (i < 6)  return "R2";
    if (i < 8)  return "R6";
    if (i < 10) return "R3";
    if (i < 11) return "R5";
    if (i < 15) return "R8";
    if (i < 20) return "R4";
    if (i < 21) return "R9";
    if (i < 25) return "R2";
    return "R5";
  endfunction

  task automatic check(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {drv_en, aux_en, spi_ready, clr_pulse, ovp_flag};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: drv/aux/rdy/clr/ovp actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(logic e, logic c, logic o);
    en_in = e; rst_gate_cmd = c; ovp_in = o;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // Reset with enable already high: no power-up afterwards (R1)
    en_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 5'b00000);
    rst = 1'b0;
    repeat (3) drive(1'b1, 1'b0, 1'b0);
    check("R1", 5'b00000);
    drive(1'b0, 1'b0, 1'b0);
    check("R1", 5'b00000);

    // Vector table walk
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][7], VEC[i][6], VEC[i][5]);
      check(req_of(i), VEC[i][4:0]);
    end

    // Ovp still present at full shutdown keeps the flag (R9)
    drive(1'b1, 1'b0, 1'b0);
    repeat (NSET) drive(1'b1, 1'b0, 1'b0);
    check("R2", 5'b11100);
    for (int k = 0; k < NLOW; k++) drive(1'b0, 1'b0, 1'b1);
    check("R9", 5'b00001);
    drive(1'b0, 1'b0, 1'b0);
    check("R9", 5'b00001);

    // Low exactly LOW_WIN_CYC-1 from settle still quick (R5)
    drive(1'b1, 1'b0, 1'b0);
    check("R2", 5'b01111);
    for (int k = 0; k < NLOW - 1; k++) drive(1'b0, 1'b0, 1'b0);
    check("R5", 5'b01101);
    drive(1'b1, 1'b0, 1'b0);
    check("R5", 5'b01111);

    // Reset mid-run forces everything off (R1)
    rst = 1'b1;
    drive(1'b1, 1'b0, 1'b0);
    check("R1", 5'b00000);
    rst = 1'b0;
    drive(1'b1, 1'b0, 1'b0);
    check("R1", 5'b00000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule